// File: doc/BRIEF.md
# ECC Error Status Capture Register

This block records data-path errors for one 64-bit slice of a shared data bus. Each transaction on the slice is two back-to-back data beats. An external decoder supplies a syndrome for each beat, along with flags that mark the beat as a single-bit or a multi-bit error. With the first beat of a transaction, the block also samples the command direction, whether the data is a control/status-register payload, whether this node can correct such a payload, and whether this node drove the data. Two separate check-error pulses report transmit-side and valid-signal parity-style faults.

The block classifies each completed transaction into one of three ECC error classes. It keeps sticky, write-1-to-clear error bits for those classes and for the two pulse faults. It also keeps a snapshot of the two beat syndromes and the transmitter flag. The snapshot belongs to the first transaction of the most severe class seen so far. A strictly more severe class replaces the snapshot, and the hard class freezes it. A lock control, once set, stops any new error from being recorded until software has cleared the existing error bits. Software reads and writes the register through a single-cycle read/write port.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset every error bit, the snapshot, the transmitter bit and the lock bit read as 0.
- R2: A transaction is a cycle with `beat_first` high, followed by the cycle right after it, which is the second beat. The syndrome of the first beat is reported in read bits [7:0] and the syndrome of the second beat in bits [15:8]. Both are taken at the clock edge of the second beat.
- R3: A transaction is classified as follows. If either beat carries a multi-bit flag, the hard-error bit (bit 17) sets. Otherwise, if either beat carries a single-bit flag, bit 18 sets for a write command or bit 19 for a read command. A transaction with no flags sets nothing.
- R4: A single-bit error on control/status data sets the hard-error bit instead of a soft bit when `csr_fixable` is low. When `csr_fixable` is high it is treated as a normal soft error.
- R5: The severity order is hard, then soft-write, then soft-read. A transaction replaces the snapshot only if its class ranks strictly above every ECC class bit still set. A transaction of an equal or lower class leaves the snapshot unchanged.
- R6: While the hard-error bit is set, the snapshot stays unchanged, whatever other errors arrive.
- R7: `tx_chk_err` sets bit 20 and `vld_chk_err` sets bit 21. Neither pulse changes the snapshot or the transmitter bit.
- R8: While the lock bit is 0, error bits accumulate: once set, a bit stays set until it is written with 1, and a single transaction or cycle may set several bits.
- R9: The lock bit (bit 24) is a plain read/write bit. While it is 1 and any of bits 17 to 21 is still set after the current write's clears, no error bit sets and the snapshot does not change.
- R10: Writing 1 to any of bits 16 to 21 clears that bit, and writing 0 has no effect. If a clear and a new setting of the same bit fall in the same cycle, the bit ends up set.
- R11: Bit 16 reads 1 when the transaction captured in the snapshot was driven by this node (`cmd_self_tx` high with its first beat). It is write-1-to-clear.
- R12: While bits 17, 18 and 19 are all 0, bits [16:0] read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_first | input | 1 | Marks the first beat of a transaction |
| beat_syn | input | 8 | ECC syndrome of the current beat |
| beat_sbe | input | 1 | Current beat has a single-bit error syndrome |
| beat_mbe | input | 1 | Current beat has a multi-bit error syndrome |
| cmd_write | input | 1 | Transaction is a write (sampled with first beat) |
| cmd_csr | input | 1 | Transaction carries control/status data (first beat) |
| csr_fixable | input | 1 | This node can correct control/status data (first beat) |
| cmd_self_tx | input | 1 | This node drove the data (first beat) |
| tx_chk_err | input | 1 | Transmit check error pulse |
| vld_chk_err | input | 1 | Valid-signal check error pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from state) |

## Verification
Every result is due one clock edge after its cause. Transaction results appear after the edge of the second beat. Pulse errors and register writes appear after the edge on which they were driven. The read value is purely combinational from the state. The bench drives each cycle's inputs on the falling edge and advances its reference state by exactly one step. It then compares the read value at the next falling edge, which is one rising edge after the drive. Directed sequences cover the ranking, freeze, lock and same-cycle clear cases. Seeded random traffic, which includes back-to-back transactions, then exercises the same rules.

// File: rtl/ecc_err_capture.sv
module ecc_err_capture #(
  parameter int SYN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_first,
  input  logic [SYN_W-1:0]  beat_syn,
  input  logic              beat_sbe,
  input  logic              beat_mbe,
  input  logic              cmd_write,
  input  logic              cmd_csr,
  input  logic              csr_fixable,
  input  logic              cmd_self_tx,
  input  logic              tx_chk_err,
  input  logic              vld_chk_err,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int TDE_B  = 2 * SYN_W;
  localparam int HARD_B = TDE_B + 1;
  localparam int SW_B   = TDE_B + 2;
  localparam int SR_B   = TDE_B + 3;
  localparam int TPE_B  = TDE_B + 4;
  localparam int VPE_B  = TDE_B + 5;
  localparam int LOCK_B = TDE_B + 8;

  // first-beat holding state
  logic             pend_q;
  logic [SYN_W-1:0] s0_hold_q;
  logic             mbe0_q, sbe0_q, wr0_q, csr0_q, fix0_q, own0_q;

  // architected state
  logic             hard_q, sw_q, sr_q, tpe_q, vpe_q, tde_q, lock_q;
  logic [SYN_W-1:0] syn0_q, syn1_q;

  logic [DATA_W-1:0] clr;
  logic              hard_k, sw_k, sr_k, tpe_k, vpe_k;
  logic              blocked, any_mbe, any_sbe, capture;
  logic [1:0]        new_rank, kept_rank, cur_rank;
  logic              take_first;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign take_first   = beat_first & ~pend_q;
  assign clr          = reg_wr ? reg_wdata : '0;

  assign hard_k = hard_q & ~clr[HARD_B];
  assign sw_k   = sw_q   & ~clr[SW_B];
  assign sr_k   = sr_q   & ~clr[SR_B];
  assign tpe_k  = tpe_q  & ~clr[TPE_B];
  assign vpe_k  = vpe_q  & ~clr[VPE_B];

  assign blocked = lock_q & (hard_k | sw_k | sr_k | tpe_k | vpe_k);

  assign any_mbe = mbe0_q | beat_mbe;
  assign any_sbe = sbe0_q | beat_sbe;

  always_comb begin
    new_rank = 2'd0;
    if (pend_q) begin
      if (any_mbe || (any_sbe && csr0_q && !fix0_q)) new_rank = 2'd3;
      else if (any_sbe && wr0_q)                     new_rank = 2'd2;
      else if (any_sbe)                              new_rank = 2'd1;
    end
  end

  assign kept_rank = hard_k ? 2'd3 : sw_k ? 2'd2 : sr_k ? 2'd1 : 2'd0;
  assign cur_rank  = hard_q ? 2'd3 : sw_q ? 2'd2 : sr_q ? 2'd1 : 2'd0;
  assign capture   = ~blocked & (new_rank > kept_rank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      s0_hold_q <= '0;
      mbe0_q    <= 1'b0;
      sbe0_q    <= 1'b0;
      wr0_q     <= 1'b0;
      csr0_q    <= 1'b0;
      fix0_q    <= 1'b0;
      own0_q    <= 1'b0;
    end else begin
      pend_q <= take_first;
      if (take_first) begin
        s0_hold_q <= beat_syn;
        mbe0_q    <= beat_mbe;
        sbe0_q    <= beat_sbe;
        wr0_q     <= cmd_write;
        csr0_q    <= cmd_csr;
        fix0_q    <= csr_fixable;
        own0_q    <= cmd_self_tx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hard_q <= 1'b0;
      sw_q   <= 1'b0;
      sr_q   <= 1'b0;
      tpe_q  <= 1'b0;
      vpe_q  <= 1'b0;
      tde_q  <= 1'b0;
      lock_q <= 1'b0;
      syn0_q <= '0;
      syn1_q <= '0;
    end else begin
      hard_q <= hard_k | (~blocked & (new_rank == 2'd3));
      sw_q   <= sw_k   | (~blocked & (new_rank == 2'd2));
      sr_q   <= sr_k   | (~blocked & (new_rank == 2'd1));
      tpe_q  <= tpe_k  | (~blocked & tx_chk_err);
      vpe_q  <= vpe_k  | (~blocked & vld_chk_err);
      if (reg_wr) lock_q <= reg_wdata[LOCK_B];
      if (capture) begin
        syn0_q <= s0_hold_q;
        syn1_q <= beat_syn;
        tde_q  <= own0_q;
      end else begin
        tde_q  <= tde_q & ~clr[TDE_B];
      end
    end
  end

  logic live;
  assign live = hard_q | sw_q | sr_q;

  always_comb begin
    reg_rdata = '0;
    if (live) begin
      reg_rdata[SYN_W-1:0]       = syn0_q;
      reg_rdata[2*SYN_W-1:SYN_W] = syn1_q;
      reg_rdata[TDE_B]           = tde_q;
    end
    reg_rdata[HARD_B] = hard_q;
    reg_rdata[SW_B]   = sw_q;
    reg_rdata[SR_B]   = sr_q;
    reg_rdata[TPE_B]  = tpe_q;
    reg_rdata[VPE_B]  = vpe_q;
    reg_rdata[LOCK_B] = lock_q;
  end

  logic [4:0] err_vec, clr_vec;
  assign err_vec = {vpe_q, tpe_q, sr_q, sw_q, hard_q};
  assign clr_vec = {clr[VPE_B], clr[TPE_B], clr[SR_B], clr[SW_B], clr[HARD_B]};

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_q && !clr[HARD_B]) |=> $stable({syn1_q, syn0_q}));

  p_cap_on_beat2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable({syn1_q, syn0_q}));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_vec & $past(err_vec & ~clr_vec)) == $past(err_vec & ~clr_vec)));

  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && |(err_vec & ~clr_vec)) |=> (err_vec == $past(err_vec & ~clr_vec)));

  p_rank_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> (cur_rank >= $past(cur_rank)));

  p_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(hard_q | sw_q | sr_q) |-> (reg_rdata[TDE_B:0] == '0));

endmodule

// File: tb/tb_ecc_err_capture.sv
module tb_ecc_err_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        beat_first, beat_sbe, beat_mbe;
  logic [7:0]  beat_syn;
  logic        cmd_write, cmd_csr, csr_fixable, cmd_self_tx;
  logic        tx_chk_err, vld_chk_err, reg_wr;
  logic [31:0] reg_wdata, reg_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ecc_err_capture dut (
    .clk(clk), .rst_n(rst_n), .beat_first(beat_first), .beat_syn(beat_syn),
    .beat_sbe(beat_sbe), .beat_mbe(beat_mbe), .cmd_write(cmd_write),
    .cmd_csr(cmd_csr), .csr_fixable(csr_fixable), .cmd_self_tx(cmd_self_tx),
    .tx_chk_err(tx_chk_err), .vld_chk_err(vld_chk_err), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // reference state
  logic       m_hard, m_sw, m_sr, m_tpe, m_vpe, m_tde, m_lock, m_pend;
  logic [7:0] m_s0, m_s1, m_h0;
  logic       m_hm, m_hs, m_hw, m_hc, m_hf, m_ho;

  function automatic int rank_of(input logic h, input logic w, input logic r);
    return h ? 3 : w ? 2 : r ? 1 : 0;
  endfunction

  function automatic logic [31:0] m_read();
    logic [31:0] v = '0;
    if (m_hard | m_sw | m_sr) v[16:0] = {m_tde, m_s1, m_s0};
    v[17] = m_hard; v[18] = m_sw; v[19] = m_sr;
    v[20] = m_tpe;  v[21] = m_vpe; v[24] = m_lock;
    return v;
  endfunction

  task automatic m_reset();
    {m_hard, m_sw, m_sr, m_tpe, m_vpe, m_tde, m_lock, m_pend} = '0;
    {m_s0, m_s1, m_h0} = '0;
    {m_hm, m_hs, m_hw, m_hc, m_hf, m_ho} = '0;
  endtask

  task automatic m_step();
    logic [31:0] c;
    logic h, w, r, t, v, blk;
    int nr;
    c = reg_wr ? reg_wdata : 32'd0;
    h = m_hard & ~c[17]; w = m_sw & ~c[18]; r = m_sr & ~c[19];
    t = m_tpe & ~c[20];  v = m_vpe & ~c[21];
    blk = m_lock & (h | w | r | t | v);
    nr = 0;
    if (m_pend) begin
      if (m_hm | beat_mbe) nr = 3;
      else if ((m_hs | beat_sbe) & m_hc & ~m_hf) nr = 3;
      else if ((m_hs | beat_sbe) & m_hw) nr = 2;
      else if (m_hs | beat_sbe) nr = 1;
    end
    if (!blk && nr > rank_of(h, w, r)) begin
      m_s0 = m_h0; m_s1 = beat_syn; m_tde = m_ho;
    end else m_tde = m_tde & ~c[16];
    m_hard = h | (!blk && nr == 3);
    m_sw   = w | (!blk && nr == 2);
    m_sr   = r | (!blk && nr == 1);
    m_tpe  = t | (!blk && tx_chk_err);
    m_vpe  = v | (!blk && vld_chk_err);
    if (reg_wr) m_lock = reg_wdata[24];
    if (beat_first && !m_pend) begin
      m_h0 = beat_syn; m_hm = beat_mbe; m_hs = beat_sbe; m_hw = cmd_write;
      m_hc = cmd_csr;  m_hf = csr_fixable; m_ho = cmd_self_tx;
      m_pend = 1'b1;
    end else m_pend = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    {beat_first, beat_sbe, beat_mbe, cmd_write, cmd_csr, csr_fixable, cmd_self_tx} = '0;
    {tx_chk_err, vld_chk_err, reg_wr} = '0;
    beat_syn = '0; reg_wdata = '0;
  endtask

  // at a falling edge: inputs already set; advance reference, wait one edge, compare
  task automatic tick(input string tag);
    m_step();
    @(negedge clk);
    check(tag, reg_rdata, m_read());
    idle_inputs();
  endtask

  task automatic txn(input string tag, input logic wr, input logic csr, input logic fix,
                     input logic own, input logic [7:0] s0, input logic sb0, input logic mb0,
                     input logic [7:0] s1, input logic sb1, input logic mb1);
    beat_first = 1; beat_syn = s0; beat_sbe = sb0; beat_mbe = mb0;
    cmd_write = wr; cmd_csr = csr; csr_fixable = fix; cmd_self_tx = own;
    tick(tag);
    beat_syn = s1; beat_sbe = sb1; beat_mbe = mb1;
    tick(tag);
  endtask

  task automatic wr_reg(input string tag, input logic [31:0] d);
    reg_wr = 1; reg_wdata = d;
    tick(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle_inputs();
    m_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1", reg_rdata, 32'h0);

    // R3/R2/R11: soft read error, own data
    txn("R3", 0, 0, 0, 1, 8'h11, 1, 0, 8'h00, 0, 0);
    check("R2", reg_rdata, 32'h0009_0011);
    // R5: equal class keeps first snapshot
    txn("R5", 0, 0, 0, 0, 8'h22, 0, 0, 8'h23, 1, 0);
    check("R5", reg_rdata, 32'h0009_0011);
    // R5: higher class (write soft) replaces
    txn("R5", 1, 0, 0, 0, 8'h33, 0, 0, 8'h44, 1, 0);
    check("R5", reg_rdata, 32'h000C_4433);
    // R3: multi-bit on second beat
    txn("R3", 1, 0, 0, 1, 8'h55, 0, 0, 8'h56, 0, 1);
    check("R3", reg_rdata, 32'h000F_5655);
    // R6: frozen
    txn("R6", 0, 0, 0, 0, 8'h66, 0, 1, 8'h67, 0, 0);
    check("R6", reg_rdata, 32'h000F_5655);
    // R7: pulse errors do not touch snapshot
    tx_chk_err = 1; tick("R7");
    vld_chk_err = 1; tick("R7");
    check("R7", reg_rdata, 32'h003F_5655);
    // R11: clear transmitter bit only
    wr_reg("R11", 32'h0001_0000);
    check("R11", reg_rdata, 32'h003E_5655);
    // R10: writing zeros has no effect, then clear all
    wr_reg("R10", 32'h0000_0000);
    check("R10", reg_rdata, 32'h003E_5655);
    wr_reg("R10", 32'h003F_0000);
    check("R12", reg_rdata, 32'h0);
    // R8: accumulation, several bits in one cycle
    tx_chk_err = 1; vld_chk_err = 1; tick("R8");
    txn("R8", 0, 0, 0, 0, 8'h01, 1, 0, 8'h02, 0, 0);
    check("R8", reg_rdata, 32'h0038_0201);
    // R10: clear and new set in same cycle -> set, snapshot recaptured
    beat_first = 1; beat_syn = 8'h0A; beat_sbe = 1; tick("R10");
    beat_syn = 8'h0B; reg_wr = 1; reg_wdata = 32'h0008_0000; tick("R10");
    check("R10", reg_rdata, 32'h0038_0B0A);
    wr_reg("R10", 32'h003F_0000);
    // R4: uncorrectable CSR single-bit -> hard; fixable -> soft
    txn("R4", 0, 1, 1, 0, 8'h0C, 1, 0, 8'h0D, 0, 0);
    check("R4", reg_rdata, 32'h0008_0D0C);
    wr_reg("R4", 32'h003F_0000);
    txn("R4", 0, 1, 0, 0, 8'h0E, 1, 0, 8'h0F, 0, 0);
    check("R4", reg_rdata, 32'h0002_0F0E);
    // R9: lock with an error present blocks new errors
    wr_reg("R9", 32'h0100_0000);
    tx_chk_err = 1; tick("R9");
    txn("R9", 1, 0, 0, 0, 8'h10, 0, 1, 8'h10, 0, 0);
    check("R9", reg_rdata, 32'h0102_0F0E);
    wr_reg("R9", 32'h013F_0000);
    tx_chk_err = 1; tick("R9");
    txn("R9", 1, 0, 0, 1, 8'h21, 1, 0, 8'h22, 0, 0);
    check("R9", reg_rdata, 32'h0110_0000);
    wr_reg("R9", 32'h003F_0000);
    check("R1", reg_rdata, 32'h0);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 99);
      beat_first  = ($urandom_range(0, 2) != 0);
      beat_syn    = 8'($urandom);
      beat_sbe    = ($urandom_range(0, 3) == 0);
      beat_mbe    = ($urandom_range(0, 15) == 0);
      cmd_write   = 1'($urandom);
      cmd_csr     = ($urandom_range(0, 3) == 0);
      csr_fixable = 1'($urandom);
      cmd_self_tx = 1'($urandom);
      tx_chk_err  = ($urandom_range(0, 30) == 0);
      vld_chk_err = ($urandom_range(0, 30) == 0);
      if (k < 8) begin
        reg_wr = 1;
        reg_wdata = $urandom & 32'h013F_0000;
      end
      tick("R8");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule